// File: doc/BRIEF.md
# Credit-Based Inter-Chip Link Gateway

This block moves packet words across a slow, fixed-latency link between two chips without ever overrunning the receiver. Each gateway has a send side and a receive side. The send side holds a credit counter that tracks the free space in the far chip's receive FIFO. A local producer offers words on `tx_valid`. A word is accepted only while credit remains, and every accepted word uses one credit. The receive side writes incoming words into a local FIFO. Each time the local consumer removes a word, one credit-release pulse goes back over the link so that the far sender regains that slot.

Each direction of the link carries a data word, one control bit, a push strobe and a credit-release strobe. The link's wire delay is modelled inside the gateway as a parameterised delay line on the outgoing beat. Two gateways are connected cross-wise, each one's outgoing link feeding the other's incoming link. Credits return fast enough to keep the sender busy every cycle when two conditions hold: the far FIFO is deeper than the round trip, and the consumer drains it at full rate.

Top module: `credit_link_gateway`

## Requirements
- R1: Out of reset the credit count equals REMOTE_DEPTH (32). In that state `tx_ready` is high and `lnk_out_push`, `lnk_out_crel` and `rx_valid` are low. Exactly REMOTE_DEPTH words can be accepted without any credit release before `tx_ready` falls.
- R2: An accepted send (`tx_valid` and `tx_ready` high in one cycle) lowers the credit count by one. A cycle with `lnk_in_crel` high raises it by one. `tx_ready` is high exactly when the count is non-zero.
- R3: While the credit count is zero, `tx_valid` is ignored: no push appears on the outgoing link and the count stays at zero.
- R4: When a send is accepted in the same cycle as `lnk_in_crel` is high, the credit count is unchanged.
- R5: An accepted word appears on `lnk_out_data`/`lnk_out_ctrl` with `lnk_out_push` high exactly LINK_LAT cycles after the cycle it was accepted in (the same cycle when LINK_LAT is 0). Its data and control bit are unchanged and words keep their order.
- R6: A cycle with `lnk_in_push` high stores the control bit and data word in the local FIFO. `rx_valid` is high from the next cycle. Words leave in arrival order, and the oldest word is shown on `rx_data`/`rx_ctrl`.
- R7: A cycle with `rx_pop` and `rx_valid` both high removes the oldest word and produces one `lnk_out_crel` pulse LINK_LAT cycles later. `rx_pop` while the FIFO is empty removes nothing and produces no pulse.
- R8: With two gateways linked cross-wise, the far FIFO never receives a push while it is full. Every word is delivered exactly once and in order, even when the far consumer drains slowly and the sender is held back.
- R9: With two gateways linked, REMOTE_DEPTH greater than the round trip of 2*LINK_LAT+2 cycles, and a consumer that pops every cycle, `tx_ready` never drops during a continuous stream: one word is sent per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Local producer offers a word |
| tx_data | input | DATA_W | Word to send |
| tx_ctrl | input | 1 | Control bit sent with the word |
| tx_ready | output | 1 | Credit available; word accepted when `tx_valid` is high |
| lnk_out_push | output | 1 | Outgoing link: word present |
| lnk_out_crel | output | 1 | Outgoing link: one credit returned to far side |
| lnk_out_ctrl | output | 1 | Outgoing link: control bit |
| lnk_out_data | output | DATA_W | Outgoing link: data word |
| lnk_in_push | input | 1 | Incoming link: word present |
| lnk_in_crel | input | 1 | Incoming link: one credit returned by far side |
| lnk_in_ctrl | input | 1 | Incoming link: control bit |
| lnk_in_data | input | DATA_W | Incoming link: data word |
| rx_valid | output | 1 | Local FIFO holds at least one word |
| rx_data | output | DATA_W | Oldest word in local FIFO |
| rx_ctrl | output | 1 | Control bit of oldest word |
| rx_pop | input | 1 | Local consumer removes the oldest word |

## Verification
The assertions rely on two assumptions about the far side. First, it never returns more credits than words it was sent, so the count cannot climb past REMOTE_DEPTH. Second, it never pushes more words than the local FIFO has room for. In the single-gateway tests the bench drives the incoming link by hand. It returns credits only after matching sends and pushes at most a handful of words before draining them. In the linked tests both assumptions hold by construction, because each gateway's credit discipline governs the other.

// File: rtl/clg_pkg.sv
package clg_pkg;

   // Bits needed to hold any value from 0 to max_val inclusive.
   function automatic int cnt_bits(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

   typedef enum logic [1:0] {
      CR_HOLD = 2'd0,
      CR_TAKE = 2'd1,
      CR_GIVE = 2'd2
   } credit_op_e;

endpackage

// File: rtl/clg_credit_ctr.sv
module clg_credit_ctr
   import clg_pkg::*;
#(
   parameter int INIT = 32
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      take,
   input  logic                      give,
   output logic                      has_credit,
   output logic [cnt_bits(INIT)-1:0] level
);
   localparam int CW = cnt_bits(INIT);

   if (INIT < 1) begin : g_bad_init
      $error("clg_credit_ctr: INIT must be at least 1");
   end

   credit_op_e op;

   always_comb begin
      case ({take, give})
         2'b10:   op = CR_TAKE;
         2'b01:   op = CR_GIVE;
         default: op = CR_HOLD;   // idle, or take and give cancel
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= CW'(INIT);
      end else begin
         case (op)
            CR_TAKE: level <= level - 1'b1;
            CR_GIVE: level <= level + 1'b1;
            default: level <= level;
         endcase
      end
   end

   assign has_credit = (level != '0);

endmodule

// File: rtl/clg_fifo.sv
module clg_fifo #(
   parameter int W     = 33,
   parameter int DEPTH = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         full,
   output logic         empty
);
   localparam int AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("clg_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("clg_fifo: W must be at least 1");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;
   logic          wr_en, rd_en;

   assign wr_en = push && !full;
   assign rd_en = pop && !empty;

   // Pointer advance: free wrap for power-of-two depth, compare otherwise.
   if (POW2) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_nxt;
         if (rd_en) rd_ptr <= rd_nxt;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign rdata = mem[rd_ptr];

endmodule

// File: rtl/clg_delay_line.sv
module clg_delay_line #(
   parameter int W      = 35,
   parameter int STAGES = 3
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("clg_delay_line: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_wire
      assign q = d;
   end else begin : g_pipe
      logic [W-1:0] stage [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
         end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
         end
      end

      assign q = stage[STAGES-1];
   end

endmodule

// File: rtl/credit_link_gateway.sv
module credit_link_gateway
   import clg_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int REMOTE_DEPTH = 32,
   parameter int LOCAL_DEPTH  = 32,
   parameter int LINK_LAT     = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_ctrl,
   output logic              tx_ready,
   output logic              lnk_out_push,
   output logic              lnk_out_crel,
   output logic              lnk_out_ctrl,
   output logic [DATA_W-1:0] lnk_out_data,
   input  logic              lnk_in_push,
   input  logic              lnk_in_crel,
   input  logic              lnk_in_ctrl,
   input  logic [DATA_W-1:0] lnk_in_data,
   output logic              rx_valid,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_ctrl,
   input  logic              rx_pop
);
   localparam int CW      = cnt_bits(REMOTE_DEPTH);
   localparam int ENTRY_W = DATA_W + 1;
   localparam int BEAT_W  = DATA_W + 3;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("credit_link_gateway: DATA_W must be at least 1");
   end
   if (REMOTE_DEPTH < 1) begin : g_bad_remote
      $error("credit_link_gateway: REMOTE_DEPTH must be at least 1");
   end
   if (LOCAL_DEPTH < 2) begin : g_bad_local
      $error("credit_link_gateway: LOCAL_DEPTH must be at least 2");
   end
   if (LINK_LAT < 0) begin : g_bad_lat
      $error("credit_link_gateway: LINK_LAT must not be negative");
   end

   // ---------------- send side ----------------
   logic          has_credit;
   logic [CW-1:0] credit_lvl;
   logic          send_fire;

   assign tx_ready  = has_credit;
   assign send_fire = tx_valid && has_credit;

   clg_credit_ctr #(
      .INIT (REMOTE_DEPTH)
   ) u_credit (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (send_fire),
      .give       (lnk_in_crel),
      .has_credit (has_credit),
      .level      (credit_lvl)
   );

   // ---------------- receive side ----------------
   logic               rx_full;
   logic               rx_empty;
   logic               pop_fire;
   logic [ENTRY_W-1:0] rx_entry;

   assign rx_valid = !rx_empty;
   assign pop_fire = rx_pop && !rx_empty;

   clg_fifo #(
      .W     (ENTRY_W),
      .DEPTH (LOCAL_DEPTH)
   ) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (lnk_in_push),
      .wdata ({lnk_in_ctrl, lnk_in_data}),
      .pop   (pop_fire),
      .rdata (rx_entry),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign rx_ctrl = rx_entry[ENTRY_W-1];
   assign rx_data = rx_entry[DATA_W-1:0];

   // ---------------- outgoing link beat ----------------
   // Beat layout: {push, credit release, ctrl, data}
   logic [BEAT_W-1:0] beat_in, beat_out;

   assign beat_in = {send_fire, pop_fire, tx_ctrl, tx_data};

   clg_delay_line #(
      .W      (BEAT_W),
      .STAGES (LINK_LAT)
   ) u_link_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (beat_in),
      .q     (beat_out)
   );

   assign lnk_out_push = beat_out[BEAT_W-1];
   assign lnk_out_crel = beat_out[BEAT_W-2];
   assign lnk_out_ctrl = beat_out[BEAT_W-3];
   assign lnk_out_data = beat_out[DATA_W-1:0];

endmodule

// File: rtl/clg_gateway_chk.sv
module clg_gateway_chk #(
   parameter int REMOTE_DEPTH = 32,
   parameter int CW           = 6
)(
   input logic          clk,
   input logic          rst_n,
   input logic          tx_valid,
   input logic          tx_ready,
   input logic          lnk_in_push,
   input logic          lnk_in_crel,
   input logic          rx_valid,
   input logic [CW-1:0] credit,
   input logic          rx_full
);
   logic send_acc;
   assign send_acc = tx_valid && tx_ready;

   AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(credit) <= REMOTE_DEPTH);                                        // R1

   AST_TAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (send_acc && !lnk_in_crel) |=> (credit == $past(credit) - 1'b1));    // R2

   AST_GIVE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!send_acc && lnk_in_crel) |=> (credit == $past(credit) + 1'b1));    // R2

   AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (credit == '0 && !lnk_in_crel) |=> (credit == '0 && !tx_ready));     // R3

   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (send_acc && lnk_in_crel) |=> $stable(credit));                      // R4

   AST_RX_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_in_push |=> rx_valid);                                           // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      lnk_in_push |-> !rx_full);                                           // R8

endmodule

bind credit_link_gateway clg_gateway_chk #(
   .REMOTE_DEPTH (REMOTE_DEPTH),
   .CW           (CW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_valid    (tx_valid),
   .tx_ready    (tx_ready),
   .lnk_in_push (lnk_in_push),
   .lnk_in_crel (lnk_in_crel),
   .rx_valid    (rx_valid),
   .credit      (credit_lvl),
   .rx_full     (rx_full)
);

// File: tb/sim_credit_link_gateway.sv
module sim_credit_link_gateway;
   localparam int DW  = 32;
   localparam int RD  = 32;
   localparam int LD  = 32;
   localparam int LAT = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   int   cyc = 0;
   always @(posedge clk) cyc++;

   int n_tests = 0;
   int n_fail  = 0;

   // ---------------- unit under test u0 ----------------
   logic          tx_valid, tx_ctrl, tx_ready;
   logic [DW-1:0] tx_data;
   logic          lo_push, lo_crel, lo_ctrl;
   logic [DW-1:0] lo_data;
   logic          li_push, li_crel, li_ctrl;
   logic [DW-1:0] li_data;
   logic          rx_valid, rx_ctrl, rx_pop;
   logic [DW-1:0] rx_data;

   credit_link_gateway #(.DATA_W(DW), .REMOTE_DEPTH(RD), .LOCAL_DEPTH(LD), .LINK_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_ready(tx_ready),
      .lnk_out_push(lo_push), .lnk_out_crel(lo_crel), .lnk_out_ctrl(lo_ctrl), .lnk_out_data(lo_data),
      .lnk_in_push(li_push), .lnk_in_crel(li_crel), .lnk_in_ctrl(li_ctrl), .lnk_in_data(li_data),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ctrl(rx_ctrl), .rx_pop(rx_pop));

   // ---------------- linked pair ua <-> ub ----------------
   logic          a_tx_valid, a_tx_ctrl, a_tx_ready;
   logic [DW-1:0] a_tx_data;
   logic          ab_push, ab_crel, ab_ctrl, ba_push, ba_crel, ba_ctrl;
   logic [DW-1:0] ab_data, ba_data;
   logic          a_rx_valid, a_rx_ctrl;
   logic [DW-1:0] a_rx_data;
   logic          b_tx_ready, b_rx_valid, b_rx_ctrl, b_rx_pop;
   logic [DW-1:0] b_rx_data;
   logic          one  = 1'b1;
   logic          zero = 1'b0;
   logic [DW-1:0] zdat = '0;

   credit_link_gateway #(.DATA_W(DW), .REMOTE_DEPTH(RD), .LOCAL_DEPTH(LD), .LINK_LAT(LAT)) ua (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(a_tx_valid), .tx_data(a_tx_data), .tx_ctrl(a_tx_ctrl), .tx_ready(a_tx_ready),
      .lnk_out_push(ab_push), .lnk_out_crel(ab_crel), .lnk_out_ctrl(ab_ctrl), .lnk_out_data(ab_data),
      .lnk_in_push(ba_push), .lnk_in_crel(ba_crel), .lnk_in_ctrl(ba_ctrl), .lnk_in_data(ba_data),
      .rx_valid(a_rx_valid), .rx_data(a_rx_data), .rx_ctrl(a_rx_ctrl), .rx_pop(one));

   credit_link_gateway #(.DATA_W(DW), .REMOTE_DEPTH(RD), .LOCAL_DEPTH(LD), .LINK_LAT(LAT)) ub (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(zero), .tx_data(zdat), .tx_ctrl(zero), .tx_ready(b_tx_ready),
      .lnk_out_push(ba_push), .lnk_out_crel(ba_crel), .lnk_out_ctrl(ba_ctrl), .lnk_out_data(ba_data),
      .lnk_in_push(ab_push), .lnk_in_crel(ab_crel), .lnk_in_ctrl(ab_ctrl), .lnk_in_data(ab_data),
      .rx_valid(b_rx_valid), .rx_data(b_rx_data), .rx_ctrl(b_rx_ctrl), .rx_pop(b_rx_pop));

   // ---------------- u0 link monitor ----------------
   int            lp_cnt = 0;
   int            lc_cnt = 0;
   logic [DW-1:0] lp_data [512];
   logic          lp_ctrl [512];
   int            lp_cyc  [512];
   int            lc_cyc  [512];

   always @(negedge clk) begin
      if (rst_n && lo_push) begin
         if (lp_cnt < 512) begin
            lp_data[lp_cnt] = lo_data;
            lp_ctrl[lp_cnt] = lo_ctrl;
            lp_cyc[lp_cnt]  = cyc;
         end
         lp_cnt++;
      end
      if (rst_n && lo_crel) begin
         if (lc_cnt < 512) lc_cyc[lc_cnt] = cyc;
         lc_cnt++;
      end
   end

   // ---------------- helpers ----------------
   task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tx_valid = 0; tx_data = '0; tx_ctrl = 0;
      li_push = 0; li_crel = 0; li_ctrl = 0; li_data = '0; rx_pop = 0;
      a_tx_valid = 0; a_tx_data = '0; a_tx_ctrl = 0; b_rx_pop = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state();
      do_reset();
      chk_eq("R1", "tx_ready after reset", tx_ready, 1);
      chk_eq("R1", "rx_valid after reset", rx_valid, 0);
      chk_eq("R1", "lnk_out_push after reset", lo_push, 0);
      chk_eq("R1", "lnk_out_crel after reset", lo_crel, 0);
   endtask

   task automatic t_credit_drain();
      int base;
      int s0;
      int lost;
      do_reset();
      base = lp_cnt;
      lost = 0;
      s0   = 0;
      for (int i = 0; i < RD; i++) begin
         @(negedge clk);
         if (!tx_ready) lost++;
         tx_valid = 1'b1;
         tx_data  = 32'hA500_0000 + i;
         tx_ctrl  = i[0];
         if (i == 0) s0 = cyc;
      end
      @(negedge clk);
      tx_valid = 1'b0;
      chk_eq("R2", "tx_ready drops during first RD sends", lost, 0);
      chk_eq("R1", "tx_ready after RD sends", tx_ready, 0);
      // R3: offer words while out of credit
      tx_valid = 1'b1;
      tx_data  = 32'hDEAD_0000;
      repeat (6) @(negedge clk);
      chk_eq("R3", "tx_ready while starved", tx_ready, 0);
      tx_valid = 1'b0;
      repeat (LAT + 2) @(negedge clk);
      chk_eq("R3", "link pushes with no credit", lp_cnt - base, RD);
      chk_eq("R5", "first word data", lp_data[base], 32'hA500_0000);
      chk_eq("R5", "first word latency", lp_cyc[base] - s0, LAT);
      chk_eq("R5", "last word data", lp_data[base + RD - 1], 32'hA500_0000 + RD - 1);
      chk_eq("R5", "last word ctrl", lp_ctrl[base + RD - 1], 1);
      chk_eq("R5", "back-to-back spacing", lp_cyc[base + RD - 1] - lp_cyc[base], RD - 1);
      // R2: one release gives one credit
      li_crel = 1'b1;
      @(negedge clk);
      li_crel = 1'b0;
      chk_eq("R2", "tx_ready after one release", tx_ready, 1);
      // R4: send and release together keep the count at one
      tx_valid = 1'b1;
      li_crel  = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      li_crel  = 1'b0;
      chk_eq("R4", "tx_ready after send+release", tx_ready, 1);
      // R2: a lone send consumes the last credit
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk_eq("R2", "tx_ready after last credit used", tx_ready, 0);
   endtask

   task automatic t_receive();
      int cb;
      int p0;
      do_reset();
      cb = lc_cnt;
      p0 = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (i == 1) chk_eq("R6", "rx_valid one cycle after first push", rx_valid, 1);
         li_push = 1'b1;
         li_data = 32'h5EED_0000 + i;
         li_ctrl = (i == 4);
      end
      @(negedge clk);
      li_push = 1'b0;
      for (int i = 0; i < 5; i++) begin
         chk_eq("R6", "rx_valid before pop", rx_valid, 1);
         chk_eq("R6", "rx_data order", rx_data, 32'h5EED_0000 + i);
         chk_eq("R6", "rx_ctrl order", rx_ctrl, (i == 4) ? 1 : 0);
         rx_pop = 1'b1;
         if (i == 0) p0 = cyc;
         @(negedge clk);
      end
      chk_eq("R7", "rx_valid after draining", rx_valid, 0);
      repeat (4) @(negedge clk);   // pop held while empty
      rx_pop = 1'b0;
      repeat (LAT + 2) @(negedge clk);
      chk_eq("R7", "credit pulses for five pops", lc_cnt - cb, 5);
      chk_eq("R7", "credit pulse latency", lc_cyc[cb] - p0, LAT);
   endtask

   task automatic t_stream(input int n, input bit slow, input string tag);
      int sent;
      int got;
      int bad;
      int stall;
      int guard;
      bit pop_now;
      do_reset();
      sent = 0; got = 0; bad = 0; stall = 0; guard = 0;
      while (got < n && guard < 5000) begin
         @(negedge clk);
         guard++;
         pop_now  = slow ? (cyc % 4 == 0) : 1'b1;
         b_rx_pop = pop_now;
         if (pop_now && b_rx_valid) begin
            if (b_rx_data != 32'(got) || b_rx_ctrl != got[0]) bad++;
            got++;
         end
         if (sent < n) begin
            a_tx_valid = 1'b1;
            a_tx_data  = 32'(sent);
            a_tx_ctrl  = sent[0];
            if (a_tx_ready) sent++;
            else stall++;
         end else begin
            a_tx_valid = 1'b0;
         end
      end
      a_tx_valid = 1'b0;
      b_rx_pop   = 1'b0;
      chk_eq("R8", {tag, " words delivered"}, got, n);
      chk_eq("R8", {tag, " words out of order"}, bad, 0);
      if (slow) chk_eq("R8", {tag, " sender held back"}, (stall > 0) ? 1 : 0, 1);
      else      chk_eq("R9", {tag, " tx_ready low cycles"}, stall, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      t_reset_state();
      t_credit_drain();
      t_receive();
      t_stream(100, 1'b0, "full-rate stream");
      t_stream(200, 1'b1, "slow consumer stream");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule